// File: doc/BRIEF.md
# Oversampled Reader Command Receiver

This block recovers byte frames from a reader-to-tag line that has already been sliced to one bit per sample. The line is sampled four times per bit period. The receiver first measures a long low start-of-frame (SOF) run. It then assembles characters made of a start bit, eight data bits sent least significant bit first, and a stop bit. An all-zero character ends the frame (EOF). Each good byte is presented on a one-cycle strobe together with its position in the frame. The end of a frame raises a one-cycle done strobe carrying the byte count.

Malformed input does not stall the receiver. A timing violation, a framing error or too many bytes moves it into a timed error-wait state. From there it returns to hunting for the next SOF. Samples are consumed only on cycles where the sample enable is high, so the line can be decimated upstream at any rate.

The control is a five-state machine:
- Idle (unsynced).
- SOF-low (measuring the SOF).
- Wait-start (line high between characters).
- Data (collecting a character).
- Error-wait.

The transitions are:
- Idle to SOF-low on a low sample.
- SOF-low to Wait-start on an accepted SOF.
- SOF-low to Error-wait on an SOF that is too short or too long.
- Wait-start to Data on a low sample.
- Wait-start to Error-wait on an over-long high gap.
- Data to Wait-start on a good byte.
- Data to Error-wait on a bad character or an overflow.
- Data to Idle on EOF.
- Error-wait to Idle after its hold time.

Top module: `osr_cmd_rx`

## Requirements
- R1: While unsynced, high samples cause no activity: no strobe, and `in_frame` stays 0. The first low sample starts SOF measurement, with that sample taken as position 0 of the first bit period.
- R2: Only cycles with `sample_en` = 1 advance the receiver. A cycle without it produces no strobe and leaves `in_frame` unchanged.
- R3: During SOF measurement the line is judged at position 2 of each 4-sample bit period. A high judged after 10 to 14 low periods accepts the SOF and sets `in_frame`. A high after fewer than 10 low periods is an error, and so is a 15th low period.
- R4: After an accepted SOF or a good byte, up to 25 further high samples are tolerated before a start bit. The 26th consecutive high sample is an error and clears `in_frame`.
- R5: A low sample while waiting starts a 10-bit character, also judged at position 2 of each bit period. The order is start, data bits 0 to 7, then stop. A character with stop = 1 and start = 0 emits its data on `byte_data` with `byte_valid` high for one cycle. `byte_idx` counts 0, 1, 2 and so on within the frame.
- R6: A character whose 10 bits are all 0 is EOF. It raises `frame_done` for one cycle, with `frame_len` equal to the number of bytes received. It clears `in_frame` and returns the receiver to unsynced.
- R7: Any other character without stop = 1 and start = 0 is an error. No byte is emitted for it, no `frame_done` follows, and `in_frame` clears.
- R8: The byte that brings the count to `MAX_BYTES` (default 8) is still emitted, and the receiver then enters error-wait, so that frame never completes. A frame of `MAX_BYTES`-1 bytes completes normally.
- R9: Error-wait ignores 11 samples and then returns to unsynced. A following well-formed frame is received in full.
- R10: The byte count restarts at 0 on every accepted SOF. `frame_len` keeps its value until the next `frame_done`.
- R11: After reset, `byte_valid`, `frame_done` and `in_frame` are 0 and `frame_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Qualifies `sample_bit` for this cycle |
| sample_bit | input | 1 | Sliced line sample, 1 = high |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_idx | output | $clog2(MAX_BYTES+1) | Position of the byte within its frame |
| frame_done | output | 1 | One-cycle strobe on EOF |
| frame_len | output | $clog2(MAX_BYTES+1) | Byte count of the last completed frame |
| in_frame | output | 1 | High from SOF acceptance until EOF or error |

## Verification
A wrong position counter moves the judging point off the middle of each bit period. On a clean stream this usually shows as corrupted bytes or framing errors within one character, about 40 samples. A wrong gap or SOF limit shows exactly at the boundary sample: `in_frame` falls one sample early or late, or a 9-period or 15-period SOF is accepted. A byte counter that does not clear shows on the next frame as a `byte_idx` sequence that does not start at 0, or as a wrong `frame_len`. A state machine stuck in error-wait shows as a whole frame that is silently lost.

// File: rtl/osr_cmd_rx_pkg.sv
package osr_cmd_rx_pkg;

    localparam int DATA_W = 8;
    localparam int CHAR_W = DATA_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF_LOW,
        ST_WAIT_START,
        ST_DATA,
        ST_ERR_WAIT
    } rx_state_e;

endpackage

// File: rtl/rx_step_counter.sv
module rx_step_counter #(
    parameter int W    = 5,
    parameter int WRAP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         wrap_en,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] WRAP_V = W'(WRAP);

    logic [W-1:0] cnt_up;
    assign cnt_up = cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (wrap_en && cnt_up >= WRAP_V) ? '0 : cnt_up;
        end
    end
endmodule

// File: rtl/rx_char_shift.sv
module rx_char_shift
    import osr_cmd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              din,
    output logic [CHAR_W-1:0] chr_nxt
);
    logic [CHAR_W-1:0] chr;

    // new bit enters at the top, older bits move toward bit 0
    assign chr_nxt = {din, chr[CHAR_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chr <= '0;
        end else if (clr) begin
            chr <= '0;
        end else if (shift_en) begin
            chr <= chr_nxt;
        end
    end
endmodule

// File: rtl/osr_cmd_rx.sv
module osr_cmd_rx
    import osr_cmd_rx_pkg::*;
#(
    parameter int SPB        = 4,
    parameter int SAMPLE_POS = 2,
    parameter int SOF_MIN    = 10,
    parameter int SOF_MAX    = 14,
    parameter int GAP_MAX    = 25,
    parameter int ERR_HOLD   = 10,
    parameter int MAX_BYTES  = 8,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              sample_bit,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [CNT_W-1:0]  byte_idx,
    output logic              frame_done,
    output logic [CNT_W-1:0]  frame_len,
    output logic              in_frame
);
    localparam int POS_LIM = (GAP_MAX > ERR_HOLD) ? GAP_MAX : ERR_HOLD;
    localparam int POS_W   = $clog2(((POS_LIM > SPB) ? POS_LIM : SPB) + 2);
    localparam int BIT_LIM = (SOF_MAX > CHAR_W) ? SOF_MAX : CHAR_W;
    localparam int BIT_W   = $clog2(BIT_LIM + 2);

    localparam logic [POS_W-1:0] P_SAMPLE = POS_W'(SAMPLE_POS);
    localparam logic [POS_W-1:0] P_GAP    = POS_W'(GAP_MAX);
    localparam logic [POS_W-1:0] P_HOLD   = POS_W'(ERR_HOLD);
    localparam logic [BIT_W-1:0] B_SOFMIN = BIT_W'(SOF_MIN);
    localparam logic [BIT_W-1:0] B_SOFMAX = BIT_W'(SOF_MAX);
    localparam logic [BIT_W-1:0] B_CHAR   = BIT_W'(CHAR_W);
    localparam logic [CNT_W-1:0] C_MAX    = CNT_W'(MAX_BYTES);

    rx_state_e st, st_nxt;

    logic [POS_W-1:0]  pos, pos_n;
    logic [BIT_W-1:0]  bitc, bit_n;
    logic [CNT_W-1:0]  bcnt, bcnt_n;
    logic [CHAR_W-1:0] chr_nxt;

    logic pos_clr, pos_inc, pos_wrap;
    logic bit_clr, bit_inc;
    logic cnt_clr, cnt_inc;
    logic sh_clr, sh_en;
    logic byte_evt, done_evt;
    logic on_sample, chr_ok, chr_eof, cnt_full;

    // sample position within a bit period, and the long-run gap/hold timer
    rx_step_counter #(.W(POS_W), .WRAP(SPB)) u_pos (
        .clk(clk), .rst_n(rst_n), .clr(pos_clr), .inc(pos_inc),
        .wrap_en(pos_wrap), .cnt(pos)
    );

    // SOF low periods, then character bits
    rx_step_counter #(.W(BIT_W), .WRAP(BIT_LIM + 1)) u_bits (
        .clk(clk), .rst_n(rst_n), .clr(bit_clr), .inc(bit_inc),
        .wrap_en(1'b0), .cnt(bitc)
    );

    // bytes in the current frame
    rx_step_counter #(.W(CNT_W), .WRAP(MAX_BYTES)) u_bytes (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .wrap_en(1'b0), .cnt(bcnt)
    );

    rx_char_shift u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
        .din(sample_bit), .chr_nxt(chr_nxt)
    );

    assign pos_n     = pos + 1'b1;
    assign bit_n     = bitc + 1'b1;
    assign bcnt_n    = bcnt + 1'b1;
    assign on_sample = (pos_n == P_SAMPLE);
    assign chr_ok    = chr_nxt[CHAR_W-1] & ~chr_nxt[0];
    assign chr_eof   = (chr_nxt == '0);
    assign cnt_full  = (bcnt_n >= C_MAX);

    always_comb begin
        st_nxt   = st;
        pos_clr  = 1'b0;
        pos_inc  = 1'b0;
        pos_wrap = 1'b0;
        bit_clr  = 1'b0;
        bit_inc  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        sh_clr   = 1'b0;
        sh_en    = 1'b0;
        byte_evt = 1'b0;
        done_evt = 1'b0;
        if (sample_en) begin
            unique case (st)
                ST_IDLE: begin
                    if (!sample_bit) begin
                        st_nxt  = ST_SOF_LOW;
                        pos_clr = 1'b1;
                        bit_clr = 1'b1;
                    end
                end
                ST_SOF_LOW: begin
                    pos_inc  = 1'b1;
                    pos_wrap = 1'b1;
                    if (on_sample) begin
                        if (sample_bit) begin
                            pos_clr = 1'b1;
                            if (bitc >= B_SOFMIN) begin
                                st_nxt  = ST_WAIT_START;
                                cnt_clr = 1'b1;
                            end else begin
                                st_nxt = ST_ERR_WAIT;
                            end
                        end else begin
                            bit_inc = 1'b1;
                            if (bit_n > B_SOFMAX) begin
                                st_nxt  = ST_ERR_WAIT;
                                pos_clr = 1'b1;
                            end
                        end
                    end
                end
                ST_WAIT_START: begin
                    if (sample_bit) begin
                        pos_inc = 1'b1;
                        if (pos_n > P_GAP) begin
                            st_nxt  = ST_ERR_WAIT;
                            pos_clr = 1'b1;
                        end
                    end else begin
                        st_nxt  = ST_DATA;
                        pos_clr = 1'b1;
                        bit_clr = 1'b1;
                        sh_clr  = 1'b1;
                    end
                end
                ST_DATA: begin
                    pos_inc  = 1'b1;
                    pos_wrap = 1'b1;
                    if (on_sample) begin
                        sh_en   = 1'b1;
                        bit_inc = 1'b1;
                        if (bit_n == B_CHAR) begin
                            if (chr_ok) begin
                                byte_evt = 1'b1;
                                cnt_inc  = 1'b1;
                                pos_clr  = 1'b1;
                                st_nxt   = cnt_full ? ST_ERR_WAIT : ST_WAIT_START;
                            end else if (chr_eof) begin
                                done_evt = 1'b1;
                                st_nxt   = ST_IDLE;
                            end else begin
                                st_nxt  = ST_ERR_WAIT;
                                pos_clr = 1'b1;
                            end
                        end
                    end
                end
                ST_ERR_WAIT: begin
                    pos_inc = 1'b1;
                    if (pos_n > P_HOLD) begin
                        st_nxt = ST_IDLE;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_idx   <= '0;
            frame_done <= 1'b0;
            frame_len  <= '0;
            in_frame   <= 1'b0;
        end else begin
            byte_valid <= byte_evt;
            frame_done <= done_evt;
            in_frame   <= (st_nxt == ST_WAIT_START) || (st_nxt == ST_DATA);
            if (byte_evt) begin
                byte_data <= chr_nxt[DATA_W:1];
                byte_idx  <= bcnt;
            end
            if (done_evt) begin
                frame_len <= bcnt;
            end
        end
    end
endmodule

// File: rtl/osr_cmd_rx_chk.sv
module osr_cmd_rx_chk #(
    parameter int MAX_BYTES = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_en,
    input logic             byte_valid,
    input logic [CNT_W-1:0] byte_idx,
    input logic             frame_done,
    input logic [CNT_W-1:0] frame_len,
    input logic             in_frame
);
    AST_QUIET_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> (!byte_valid && !frame_done)); // R2

    AST_FRAME_HELD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(in_frame)); // R2

    AST_BYTE_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (byte_idx < CNT_W'(MAX_BYTES))); // R8

    AST_BYTE_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && (byte_idx < CNT_W'(MAX_BYTES - 1))) |-> in_frame); // R5

    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!byte_valid && !in_frame)); // R6

    AST_LEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(frame_len)); // R10
endmodule

bind osr_cmd_rx osr_cmd_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_osr_chk (.*);

// File: tb/osr_cmd_rx_bench.sv
module osr_cmd_rx_bench;
    localparam int MAXB  = 8;
    localparam int CNT_W = $clog2(MAXB + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sample_en = 1'b0;
    logic             sample_bit = 1'b1;
    logic             byte_valid;
    logic [7:0]       byte_data;
    logic [CNT_W-1:0] byte_idx;
    logic             frame_done;
    logic [CNT_W-1:0] frame_len;
    logic             in_frame;

    osr_cmd_rx #(.MAX_BYTES(MAXB)) u_osr_cmd_rx (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_bit(sample_bit),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_idx(byte_idx),
        .frame_done(frame_done), .frame_len(frame_len), .in_frame(in_frame)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    logic [7:0] got [0:31];
    logic [7:0] tx [0:15];
    int got_n, done_n, last_len, idx_bad, gap_bad, gap_cycles;
    bit saw_in;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic clear_log();
        got_n = 0; done_n = 0; last_len = -1; idx_bad = 0; gap_bad = 0; saw_in = 0;
    endtask

    task automatic observe();
        if (byte_valid) begin
            if (int'(byte_idx) != got_n) idx_bad++;
            if (got_n < 32) got[got_n] = byte_data;
            got_n++;
        end
        if (frame_done) begin
            done_n++;
            last_len = int'(frame_len);
        end
        if (in_frame) saw_in = 1;
    endtask

    task automatic push(input logic b);
        @(negedge clk);
        sample_en  = 1'b1;
        sample_bit = b;
        @(posedge clk);
        #2;
        observe();
        if (gap_cycles > 0) begin
            @(negedge clk);
            sample_en  = 1'b0;
            sample_bit = ~b;
            for (int g = 0; g < gap_cycles; g++) begin
                @(posedge clk);
                #2;
                if (byte_valid || frame_done) gap_bad++;
            end
        end
    endtask

    task automatic send_bit(input logic b);
        repeat (4) push(b);
    endtask

    task automatic send_char(input logic [7:0] d, input logic stop);
        send_bit(1'b0);
        for (int j = 0; j < 8; j++) send_bit(d[j]);
        send_bit(stop);
    endtask

    task automatic send_eof();
        repeat (10) send_bit(1'b0);
        repeat (8) send_bit(1'b1);
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    // idle, SOF of sof_low periods, two gap bits, n characters, EOF
    task automatic send_frame(input int n, input int sof_low, input int bad_stop);
        repeat (3) send_bit(1'b1);
        repeat (sof_low) send_bit(1'b0);
        repeat (2) send_bit(1'b1);
        for (int i = 0; i < n; i++) begin
            send_char(tx[i], (i == bad_stop) ? 1'b0 : 1'b1);
            send_bit(1'b1);
        end
        send_eof();
    endtask

    function automatic int mism(input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (got[i] != tx[i]) m++;
        return m;
    endfunction

    task automatic t_reset();
        chk("R11", "byte_valid after reset", int'(byte_valid), 0);
        chk("R11", "frame_done after reset", int'(frame_done), 0);
        chk("R11", "in_frame after reset", int'(in_frame), 0);
        chk("R11", "frame_len after reset", int'(frame_len), 0);
    endtask

    task automatic t_idle();
        clear_log();
        repeat (40) push(1'b1);
        @(negedge clk) sample_en = 1'b0;
        chk("R1", "bytes while idle high", got_n, 0);
        chk("R1", "in_frame seen while idle", int'(saw_in), 0);
    endtask

    task automatic t_basic();
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h00; tx[3] = 8'hFF; tx[4] = 8'h81;
        clear_log();
        send_frame(5, 10, -1);
        chk("R5", "byte count", got_n, 5);
        chk("R5", "byte mismatches", mism(5), 0);
        chk("R5", "byte_idx errors", idx_bad, 0);
        chk("R6", "frame_done count", done_n, 1);
        chk("R6", "frame_len", last_len, 5);
        chk("R6", "in_frame seen during frame", int'(saw_in), 1);
        chk("R6", "in_frame after EOF", int'(in_frame), 0);
    endtask

    task automatic t_sof_long_ok();
        tx[0] = 8'h12; tx[1] = 8'hE7;
        clear_log();
        send_frame(2, 14, -1);
        chk("R3", "14-period SOF frame_done", done_n, 1);
        chk("R3", "14-period SOF bytes", mism(2) + (got_n == 2 ? 0 : 100), 0);
        chk("R10", "frame_len restarted", last_len, 2);
    endtask

    task automatic t_sof_bad(input int lows);
        tx[0] = 8'h5A; tx[1] = 8'h6B;
        clear_log();
        send_frame(2, lows, -1);
        chk("R3", $sformatf("%0d-period SOF bytes", lows), got_n, 0);
        chk("R3", $sformatf("%0d-period SOF frame_done", lows), done_n, 0);
    endtask

    task automatic t_gap_limit();
        clear_log();
        repeat (3) send_bit(1'b1);
        repeat (10) send_bit(1'b0);
        repeat (3) push(1'b1);
        chk("R3", "in_frame after SOF accepted", int'(in_frame), 1);
        repeat (25) push(1'b1);
        chk("R4", "in_frame after 25 gap samples", int'(in_frame), 1);
        push(1'b1);
        chk("R4", "in_frame after 26th gap sample", int'(in_frame), 0);
        repeat (8) send_bit(1'b1);
        @(negedge clk) sample_en = 1'b0;
    endtask

    task automatic t_gap_edge();
        clear_log();
        repeat (3) send_bit(1'b1);
        repeat (10) send_bit(1'b0);
        repeat (28) push(1'b1);
        send_char(8'hC3, 1'b1);
        send_bit(1'b1);
        send_eof();
        chk("R4", "frame after 25-sample gap done", done_n, 1);
        chk("R4", "byte after 25-sample gap", (got_n == 1) ? int'(got[0]) : -1, 8'hC3);
    endtask

    task automatic t_bad_stop();
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
        clear_log();
        send_frame(4, 10, 1);
        chk("R7", "bytes before bad character", got_n, 1);
        chk("R7", "frame_done after bad character", done_n, 0);
        chk("R7", "in_frame after bad character", int'(in_frame), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 16; i++) tx[i] = 8'(8'h30 + i);
        clear_log();
        send_frame(MAXB, 10, -1);
        chk("R8", "bytes emitted at overflow", got_n, MAXB);
        chk("R8", "byte mismatches at overflow", mism(MAXB), 0);
        chk("R8", "frame_done on overflow", done_n, 0);
        chk("R10", "frame_len held across overflow", int'(frame_len), 2);
        clear_log();
        send_frame(MAXB - 1, 10, -1);
        chk("R8", "frame one below limit done", done_n, 1);
        chk("R8", "frame one below limit len", last_len, MAXB - 1);
        chk("R10", "byte_idx restarted", idx_bad, 0);
    endtask

    task automatic t_recover();
        tx[0] = 8'h9E;
        clear_log();
        repeat (3) send_bit(1'b1);
        repeat (9) send_bit(1'b0);
        repeat (3) push(1'b1);
        repeat (11) push(1'b1);
        repeat (10) send_bit(1'b0);
        repeat (2) send_bit(1'b1);
        send_char(tx[0], 1'b1);
        send_bit(1'b1);
        send_eof();
        chk("R9", "frame after error-wait done", done_n, 1);
        chk("R9", "frame after error-wait len", last_len, 1);
    endtask

    task automatic t_enable_gaps();
        tx[0] = 8'h5C; tx[1] = 8'hA3; tx[2] = 8'h01;
        clear_log();
        gap_cycles = 2;
        send_frame(3, 11, -1);
        gap_cycles = 0;
        chk("R2", "gapped frame done", done_n, 1);
        chk("R2", "gapped frame bytes", mism(3) + (got_n == 3 ? 0 : 100), 0);
        chk("R2", "strobes on disabled cycles", gap_bad, 0);
    endtask

    initial begin
        gap_cycles = 0;
        clear_log();
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_idle();
        t_basic();
        t_sof_long_ok();
        t_sof_bad(9);
        t_sof_bad(15);
        t_gap_limit();
        t_gap_edge();
        t_bad_stop();
        t_sof_long_ok();
        t_overflow();
        t_recover();
        t_enable_gaps();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule